// File: doc/BRIEF.md
# Single-Byte Read Bus Master

This block is a bus master for a pipelined on-chip bus in which each transfer has an address phase followed by a data phase. The address phase of one transfer overlaps the data phase of the transfer before it. A local requester hands over a 32-bit byte address with a valid/ready handshake. The master then issues one non-sequential, non-burst byte read, waits out any stall the slave inserts, and returns the addressed byte with a one-cycle done pulse. An error response from the slave raises a flag that travels with the done pulse.

The master marks its single transfer as non-sequential for exactly one accepted address phase. From the next cycle it shows the idle transfer type, and it keeps showing idle through every wait state unless a new local request is waiting. While the slave stalls, a pending address phase is held unchanged on the bus. The byte lane is chosen by the low address bits, which the master records when the address phase is accepted. A request that arrives in the same cycle as an address-phase acceptance is issued back-to-back.

Top module: `byte_read_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_trans` is idle (2'b00), `done` is low and `req_ready` is high.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. In the next cycle `bus_trans` is non-sequential (2'b10), `bus_addr` equals the taken address, `bus_write` is 0, `bus_size` is 3'b000 (byte) and `bus_burst` is 3'b000 (single).
- R3: If the address phase is accepted (`bus_ready` high) and no new request is taken in that cycle, `bus_trans` is idle from the next cycle on, including every cycle in which the data phase is stalled.
- R4: While a non-sequential address phase sees `bus_ready` low, `bus_trans` and `bus_addr` stay unchanged and `req_ready` is low.
- R5: A data phase ends in the first cycle it sees `bus_ready` high. `done` is high for one cycle, in the cycle after that, once for each transfer, and is low while the data phase is stalled.
- R6: `done_data` equals bits [8*k+7:8*k] of `bus_rdata` in the completing cycle, where k is bits [1:0] of that transfer's address (little-endian lanes).
- R7: `done_err` equals `bus_resp` (1 = error) as sampled in the completing cycle. After an error the master returns to idle when no request is waiting.
- R8: A request taken in the same cycle that the current address phase is accepted is issued as non-sequential in the next cycle with no idle cycle between. Both transfers complete in order.
- R9: `bus_trans` only ever takes the idle (2'b00) or non-sequential (2'b10) code. Busy (2'b01) and sequential (2'b11) are never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Local read request present |
| req_ready | output | 1 | Master can take the request |
| req_addr | input | 32 | Byte address to read |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 8 | Byte that was read |
| done_err | output | 1 | Completed transfer got an error response |
| bus_addr | output | 32 | Address-phase address |
| bus_trans | output | 2 | Transfer type: 00 idle, 10 non-sequential |
| bus_write | output | 1 | Direction, always read (0) |
| bus_size | output | 3 | Transfer size, byte (000) |
| bus_burst | output | 3 | Burst type, single (000) |
| bus_ready | input | 1 | Slave ready; low stretches the current phases |
| bus_resp | input | 1 | Slave response, 1 = error |
| bus_rdata | input | 32 | Read data bus |

## Verification
Single reads are run with zero, one, three and five stall cycles, and each uses a different byte lane. This separates lane selection from completion timing, and shows whether idle is held over stalls of any length. A read that is stalled with a request queued behind it shows whether a waiting address phase is held on the bus while the earlier data phase is still open. A back-to-back pair tells a truly pipelined issue apart from one that inserts an idle cycle between transfers. An error completion, with the flag set during the stall as well as at the end, checks that the error reaches the requester together with the done pulse.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] SIZE_BYTE  = 3'b000;
  localparam logic [2:0] BURST_ONE  = 3'b000;
  localparam int unsigned BYTE_W    = 8;

  // Lowest bit position of a byte lane on the read data bus.
  function automatic int unsigned lane_lsb(input int unsigned lane);
    return lane * BYTE_W;
  endfunction

  // Number of byte lanes on a data bus of the given width.
  function automatic int unsigned lane_count(input int unsigned data_w);
    return data_w / BYTE_W;
  endfunction

endpackage

// File: rtl/brm_addr_stage.sv
module brm_addr_stage
  import brm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bus_ready,
  output logic              req_ready,
  output logic              req_take,
  output logic              ap_valid,
  output logic              ap_take,
  output logic [ADDR_W-1:0] ap_addr,
  output logic [1:0]        bus_trans
);

  always_comb begin
    // A new request may enter when the slot is empty or is being vacated.
    req_ready = !ap_valid || bus_ready;
    req_take  = req_valid && req_ready;
    ap_take   = ap_valid && bus_ready;
    bus_trans = ap_valid ? TR_NONSEQ : TR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_valid <= 1'b0;
      ap_addr  <= '0;
    end else if (req_take) begin
      ap_valid <= 1'b1;
      ap_addr  <= req_addr;
    end else if (ap_take) begin
      ap_valid <= 1'b0;
    end
  end

  // R2: a taken request is shown as non-sequential with its own address
  p_issue_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (bus_trans == TR_NONSEQ && ap_addr == $past(req_addr)));

  // R3: accepted address phase with nothing queued leaves the bus idle
  p_idle_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_take && !req_take) |=> (bus_trans == TR_IDLE));

  // R3: idle is held while nothing new is taken
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_IDLE && !req_valid) |=> (bus_trans == TR_IDLE));

  // R4: a stalled address phase is frozen
  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && !bus_ready) |=> (bus_trans == TR_NONSEQ && $stable(ap_addr)));

endmodule

// File: rtl/brm_data_stage.sv
module brm_data_stage
  import brm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_take,
  input  logic [LANE_W-1:0] ap_lane,
  input  logic              bus_ready,
  input  logic              bus_resp,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              dp_valid,
  output logic              dp_finish,
  output logic [BYTE_W-1:0] pick_byte,
  output logic              pick_err
);

  localparam int unsigned LANES = lane_count(DATA_W);

  logic [LANE_W-1:0] dp_lane;
  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = bus_rdata[lane_lsb(g) +: BYTE_W];
  end

  always_comb begin
    dp_finish = dp_valid && bus_ready;
    pick_byte = lane_bytes[dp_lane];
    pick_err  = bus_resp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_lane  <= '0;
    end else if (ap_take) begin
      dp_valid <= 1'b1;
      dp_lane  <= ap_lane;
    end else if (dp_finish) begin
      dp_valid <= 1'b0;
    end
  end

  // R5: an accepted address phase always opens a data phase
  p_phase_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_take |=> dp_valid);

  // R6: a stalled data phase keeps its lane selection
  p_lane_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !bus_ready) |=> (dp_valid && $stable(dp_lane)));

endmodule

// File: rtl/brm_result.sv
module brm_result
  import brm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_finish,
  input  logic [BYTE_W-1:0] pick_byte,
  input  logic              pick_err,
  output logic              done,
  output logic [BYTE_W-1:0] done_data,
  output logic              done_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_data <= '0;
      done_err  <= 1'b0;
    end else begin
      done <= dp_finish;
      if (dp_finish) begin
        done_data <= pick_byte;
        done_err  <= pick_err;
      end
    end
  end

endmodule

// File: rtl/byte_read_master.sv
module byte_read_master
  import brm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done,
  output logic [7:0]        done_data,
  output logic              done_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic [2:0]        bus_burst,
  input  logic              bus_ready,
  input  logic              bus_resp,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned LANES  = lane_count(DATA_W);
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Internal events brought out for the checks
  logic              req_take;
  logic              ap_valid;
  logic              ap_take;
  logic [ADDR_W-1:0] ap_addr;
  logic              dp_valid;
  logic              dp_finish;
  logic [7:0]        pick_byte;
  logic              pick_err;

  brm_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .bus_ready (bus_ready),
    .req_ready (req_ready),
    .req_take  (req_take),
    .ap_valid  (ap_valid),
    .ap_take   (ap_take),
    .ap_addr   (ap_addr),
    .bus_trans (bus_trans)
  );

  brm_data_stage #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ap_take   (ap_take),
    .ap_lane   (ap_addr[LANE_W-1:0]),
    .bus_ready (bus_ready),
    .bus_resp  (bus_resp),
    .bus_rdata (bus_rdata),
    .dp_valid  (dp_valid),
    .dp_finish (dp_finish),
    .pick_byte (pick_byte),
    .pick_err  (pick_err)
  );

  brm_result u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_finish (dp_finish),
    .pick_byte (pick_byte),
    .pick_err  (pick_err),
    .done      (done),
    .done_data (done_data),
    .done_err  (done_err)
  );

  always_comb begin
    bus_addr  = ap_addr;
    bus_write = 1'b0;
    bus_size  = SIZE_BYTE;
    bus_burst = BURST_ONE;
  end

  // R9: only idle or non-sequential codes reach the bus
  p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_IDLE || bus_trans == TR_NONSEQ));

  // R5: a done pulse follows an open data phase
  p_done_from_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dp_valid));

  // R5: a stalled data phase gives no done in the next cycle
  p_no_done_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !bus_ready) |=> !done);

  // R8: a queued request with an accepted phase stays non-sequential
  p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_take && req_take) |=> (bus_trans == TR_NONSEQ && dp_valid));

endmodule

// File: tb/test_byte_read_master.sv
`timescale 1ns/1ps
module test_byte_read_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        done;
  logic [7:0]  done_data;
  logic        done_err;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic        bus_write;
  logic [2:0]  bus_size;
  logic [2:0]  bus_burst;
  logic        bus_ready;
  logic        bus_resp;
  logic [31:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  byte_read_master i_byte_read_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .done(done), .done_data(done_data), .done_err(done_err),
    .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_write(bus_write),
    .bus_size(bus_size), .bus_burst(bus_burst), .bus_ready(bus_ready),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(input logic [31:0] data, input logic [31:0] addr);
    logic [31:0] shifted;
    shifted = data >> (addr[1:0] * 8);
    return shifted[7:0];
  endfunction

  // Monitor for illegal transfer codes (R9)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (bus_trans === 2'b01 || bus_trans === 2'b11)) begin
      checks++;
      failures++;
      $display("FAIL R9 actual=%0h expected=0 or 2", bus_trans);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_addr = 0;
    bus_ready = 1; bus_resp = 0; bus_rdata = 0;
    repeat (3) @(negedge clk);
    check(bus_trans, 2'b00, "R1 trans in reset");
    check(done, 0, "R1 done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_trans, 2'b00, "R1 trans after reset");
    check(req_ready, 1, "R1 ready after reset");
    check(done, 0, "R1 done after reset");
  endtask

  task automatic single_read(input logic [31:0] a, input int waits,
                             input logic [31:0] d, input logic e);
    @(negedge clk);
    req_valid = 1; req_addr = a; bus_ready = 1; bus_resp = 0;
    check(req_ready, 1, "R2 ready");
    @(negedge clk);
    req_valid = 0;
    check(bus_trans, 2'b10, "R2 nonseq");
    check(bus_addr, a, "R2 addr");
    check({bus_write, bus_size, bus_burst}, 7'b0, "R2 ctrl");
    @(negedge clk);
    check(bus_trans, 2'b00, "R3 idle after accept");
    for (int w = 0; w < waits; w++) begin
      bus_ready = 0; bus_resp = e;
      @(negedge clk);
      check(bus_trans, 2'b00, "R3 idle in wait");
      check(done, 0, "R5 no done in wait");
    end
    bus_ready = 1; bus_resp = e; bus_rdata = d;
    @(negedge clk);
    bus_resp = 0; bus_rdata = 0;
    check(done, 1, "R5 done");
    check(done_data, expect_byte(d, a), "R6 byte lane");
    check(done_err, e, "R7 err flag");
    check(bus_trans, 2'b00, "R7 idle after end");
    @(negedge clk);
    check(done, 0, "R5 single pulse");
  endtask

  task automatic overlap_read(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    req_valid = 1; req_addr = a; bus_ready = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    bus_ready = 0; req_valid = 1; req_addr = b;
    check(req_ready, 1, "R4 slot free in wait");
    @(negedge clk);
    req_valid = 0; req_addr = 32'hdead_beef;
    for (int k = 0; k < 3; k++) begin
      check(bus_trans, 2'b10, "R4 nonseq held");
      check(bus_addr, b, "R4 addr held");
      check(req_ready, 0, "R4 ready low");
      check(done, 0, "R5 no done in wait");
      if (k < 2) @(negedge clk);
    end
    bus_ready = 1; bus_rdata = da;
    @(negedge clk);
    check(done, 1, "R5 first done");
    check(done_data, expect_byte(da, a), "R6 first byte");
    check(bus_trans, 2'b00, "R3 idle after second accept");
    bus_rdata = db;
    @(negedge clk);
    check(done, 1, "R5 second done");
    check(done_data, expect_byte(db, b), "R6 second byte");
    bus_rdata = 0;
    @(negedge clk);
    check(done, 0, "R5 pulse ends");
  endtask

  task automatic back_to_back(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    req_valid = 1; req_addr = a; bus_ready = 1;
    @(negedge clk);
    req_addr = b;
    check(req_ready, 1, "R8 ready on accept");
    check(bus_addr, a, "R8 first addr");
    @(negedge clk);
    req_valid = 0;
    check(bus_trans, 2'b10, "R8 no idle gap");
    check(bus_addr, b, "R8 second addr");
    bus_rdata = da;
    @(negedge clk);
    check(done, 1, "R8 first done");
    check(done_data, expect_byte(da, a), "R8 first byte");
    check(bus_trans, 2'b00, "R9 idle after pair");
    bus_rdata = db;
    @(negedge clk);
    check(done, 1, "R8 second done");
    check(done_data, expect_byte(db, b), "R8 second byte");
    bus_rdata = 0;
    @(negedge clk);
    check(done, 0, "R5 pulse ends");
  endtask

  initial begin
    do_reset();
    single_read(32'h1000_0000, 0, 32'h4433_2211, 1'b0);
    single_read(32'h1000_0001, 1, 32'h8877_6655, 1'b0);
    single_read(32'h2000_0002, 3, 32'hccbb_aa99, 1'b0);
    single_read(32'h3000_0003, 5, 32'h0fed_cba9, 1'b0);
    single_read(32'h4000_0002, 1, 32'h1234_5678, 1'b1);
    single_read(32'h4000_0001, 0, 32'h9abc_def0, 1'b0);
    overlap_read(32'h5000_0003, 32'h6000_0000, 32'haa00_0000, 32'h0000_0055);
    back_to_back(32'h7000_0001, 32'h7000_0002, 32'h0000_c300, 32'h003c_0000);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule